// File: doc/BRIEF.md
# Matrix row and column sum accelerator

This block sits beside a scalar core as a command-driven coprocessor. The core hands it a 32-bit opcode and two 64-bit operands. The block replies with one 64-bit result. Three commands are decoded. A configure command records the matrix dimension n and a base address. A row command returns the sum of one row. A column command returns the sum of one column. The matrix is n by n, holds 64-bit elements, and sits in memory in row-major order, so element (r,c) lives at base + 8*(r*n + c). All sums wrap modulo 2^64.

Memory is reached through a load request port and a tagged response port. The block issues one load at a time. It fetches one element per request. While a row is walked for the first time, each fetched element is also added into a register that belongs to its column. A per-row visited bitmap records which rows have been folded in. Once every row up to n has its bit set, a column command is answered straight from its register and makes no memory request. Before that point, a column command walks the column in memory.

Top module: `msum_accel`

## Requirements
- R1: Opcode bits [1:0] = 0 configures the block. cmd_rs1_i holds n (1..NMAX) and cmd_rs2_i holds the 8-byte-aligned base. The command clears every column register and every visited bit, and it responds with 0 without touching memory.
- R2: Opcode 1 returns the sum modulo 2^64 of row cmd_rs1_i. The row is read by exactly n loads at base + 8*(r*n + c).
- R3: Opcode 2, issued while some row below n is unvisited, returns the sum of column cmd_rs1_i. It reads exactly n loads at base + 8*(r*n + c) and leaves the column registers unchanged.
- R4: The first row command for a row adds each of its elements into that element's column register. A repeated row command for the same row still returns the row sum, but it adds nothing to the column registers.
- R5: Once all n rows are visited, opcode 2 returns the column's register value and issues no memory request.
- R6: cmd_ready_o is high only when no command is in progress. A response holds rsp_valid_o and rsp_data_o steady until rsp_ready_i is high. No command is accepted before that response is taken.
- R7: At most one load is outstanding. A request holds its address and tag while mem_req_ready_i is low. Every request has type 0 (load), byte mask 0xFF, an 8-byte-aligned address and zero store data.
- R8: A memory response whose tag differs from the outstanding request's tag is ignored.
- R9: Opcode bits [1:0] = 3 respond with 0 and change no state. Opcode bits [31:2] are not decoded.
- R10: During reset cmd_ready_o is high, and rsp_valid_o and mem_req_valid_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command offered |
| cmd_ready_o | output | 1 | Command accepted when high with cmd_valid_i |
| cmd_opcode_i | input | 32 | Command opcode; bits [1:0] select the operation |
| cmd_rs1_i | input | 64 | First operand: n, or row/column index |
| cmd_rs2_i | input | 64 | Second operand: base address |
| rsp_valid_o | output | 1 | Result available |
| rsp_ready_i | input | 1 | Result taken |
| rsp_data_o | output | 64 | Result value |
| mem_req_valid_o | output | 1 | Load request valid |
| mem_req_ready_i | input | 1 | Memory accepts request |
| mem_req_tag_o | output | TAG_W | Request tag |
| mem_req_mask_o | output | 8 | Byte mask |
| mem_req_type_o | output | 2 | Access type, 0 = load |
| mem_req_addr_o | output | 64 | Byte address |
| mem_req_wdata_o | output | 64 | Store data (always zero) |
| mem_rsp_valid_i | input | 1 | Response valid |
| mem_rsp_tag_i | input | TAG_W | Response tag |
| mem_rsp_mask_i | input | 8 | Response byte mask (not used) |
| mem_rsp_data_i | input | 64 | Load data |

## Verification
The properties rely on four conditions. The host keeps n between 1 and NMAX and keeps indices below n. The base is 8-byte aligned. Memory returns exactly one correctly tagged response per accepted request, never earlier than the cycle after acceptance. Stray responses may carry other tags. The stimulus meets these conditions by configuring only n values from 1 to 16 with aligned bases and addressing only rows and columns inside the matrix. Its memory model answers each accepted load after one to three idle cycles. One cycle before each real response, it injects a stray response with a flipped tag and poisoned data.

// File: rtl/msum_pkg.sv
package msum_pkg;
  typedef enum logic [1:0] {
    OP_SETUP  = 2'd0,
    OP_ROWSUM = 2'd1,
    OP_COLSUM = 2'd2,
    OP_NONE   = 2'd3
  } op_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_REQ,
    ST_WAIT,
    ST_RESP
  } st_e;

  localparam logic [1:0] MEM_LOAD      = 2'd0;
  localparam logic [7:0] MEM_FULL_MASK = 8'hFF;
endpackage

// File: rtl/msum_addr_gen.sv
module msum_addr_gen #(
  parameter int NMAX  = 16,
  localparam int IDX_W = (NMAX > 1) ? $clog2(NMAX) : 1,
  localparam int CNT_W = $clog2(NMAX + 1)
) (
  input  logic [63:0]      base_i,
  input  logic [CNT_W-1:0] n_i,
  input  logic             row_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [IDX_W-1:0] k_i,
  output logic [63:0]      addr_o
);
  logic [63:0] major, minor, lin;

  // row walk: idx is the row, k runs over columns; column walk swaps them
  assign major  = row_i ? 64'(idx_i) : 64'(k_i);
  assign minor  = row_i ? 64'(k_i)   : 64'(idx_i);
  assign lin    = major * 64'(n_i) + minor;
  assign addr_o = base_i + (lin << 3);
endmodule

// File: rtl/msum_colbank.sv
module msum_colbank #(
  parameter int NMAX  = 16,
  localparam int IDX_W = (NMAX > 1) ? $clog2(NMAX) : 1,
  localparam int CNT_W = $clog2(NMAX + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] n_i,
  input  logic             clr_i,
  input  logic             add_i,
  input  logic [IDX_W-1:0] add_idx_i,
  input  logic [63:0]      add_data_i,
  input  logic             mark_i,
  input  logic [IDX_W-1:0] mark_idx_i,
  input  logic [IDX_W-1:0] sel_idx_i,
  output logic [63:0]      sel_data_o,
  output logic [NMAX-1:0]  seen_o,
  output logic             all_seen_o
);
  logic [NMAX-1:0][63:0] part_q;
  logic [NMAX-1:0]       seen_q;
  logic [NMAX-1:0]       in_rng;

  for (genvar g = 0; g < NMAX; g++) begin : g_col
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        part_q[g] <= '0;
        seen_q[g] <= 1'b0;
      end else if (clr_i) begin
        part_q[g] <= '0;
        seen_q[g] <= 1'b0;
      end else begin
        if (add_i && add_idx_i == IDX_W'(g)) part_q[g] <= part_q[g] + add_data_i;
        if (mark_i && mark_idx_i == IDX_W'(g)) seen_q[g] <= 1'b1;
      end
    end
    assign in_rng[g] = (CNT_W'(g) < n_i);
  end

  assign sel_data_o = part_q[sel_idx_i];
  assign seen_o     = seen_q;
  assign all_seen_o = &(seen_q | ~in_rng);
endmodule

// File: rtl/msum_ctrl.sv
module msum_ctrl
  import msum_pkg::*;
#(
  parameter int NMAX  = 16,
  parameter int TAG_W = 4,
  localparam int IDX_W = (NMAX > 1) ? $clog2(NMAX) : 1,
  localparam int CNT_W = $clog2(NMAX + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cmd_valid_i,
  output logic             cmd_ready_o,
  input  logic [31:0]      cmd_opcode_i,
  input  logic [63:0]      cmd_rs1_i,
  input  logic [63:0]      cmd_rs2_i,
  output logic             rsp_valid_o,
  input  logic             rsp_ready_i,
  output logic [63:0]      rsp_data_o,
  output logic             mem_req_valid_o,
  input  logic             mem_req_ready_i,
  output logic [TAG_W-1:0] mem_req_tag_o,
  input  logic             mem_rsp_valid_i,
  input  logic [TAG_W-1:0] mem_rsp_tag_i,
  input  logic [63:0]      mem_rsp_data_i,
  output logic [CNT_W-1:0] n_o,
  output logic [63:0]      base_o,
  output logic             walk_row_o,
  output logic [IDX_W-1:0] walk_idx_o,
  output logic [IDX_W-1:0] walk_k_o,
  output logic             clr_o,
  output logic             add_o,
  output logic [IDX_W-1:0] add_idx_o,
  output logic [63:0]      add_data_o,
  output logic             mark_o,
  output logic [IDX_W-1:0] mark_idx_o,
  output logic [IDX_W-1:0] sel_idx_o,
  input  logic [63:0]      sel_data_i,
  input  logic [NMAX-1:0]  seen_i,
  input  logic             all_seen_i
);
  st_e              st_q;
  logic [CNT_W-1:0] n_q;
  logic [63:0]      base_q, acc_q, rsp_q;
  logic             row_q, fold_q;
  logic [IDX_W-1:0] idx_q, k_q;
  logic [TAG_W-1:0] tag_q;

  op_e              op;
  logic [IDX_W-1:0] cmd_idx;
  logic             fire, hit, last;
  logic [63:0]      sum_nxt;
  logic             unused_cmd;

  assign op         = op_e'(cmd_opcode_i[1:0]);
  assign cmd_idx    = cmd_rs1_i[IDX_W-1:0];
  assign unused_cmd = ^{cmd_opcode_i[31:2], cmd_rs1_i[63:CNT_W]};
  assign fire       = cmd_valid_i && (st_q == ST_IDLE);
  assign hit        = (st_q == ST_WAIT) && mem_rsp_valid_i && (mem_rsp_tag_i == tag_q);
  assign last       = (CNT_W'(k_q) == n_q - CNT_W'(1));
  assign sum_nxt    = acc_q + mem_rsp_data_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      n_q    <= CNT_W'(1);
      base_q <= '0;
      acc_q  <= '0;
      rsp_q  <= '0;
      row_q  <= 1'b0;
      fold_q <= 1'b0;
      idx_q  <= '0;
      k_q    <= '0;
      tag_q  <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (cmd_valid_i) begin
          unique case (op)
            OP_SETUP: begin
              n_q    <= cmd_rs1_i[CNT_W-1:0];
              base_q <= cmd_rs2_i;
              rsp_q  <= '0;
              st_q   <= ST_RESP;
            end
            OP_ROWSUM: begin
              row_q  <= 1'b1;
              idx_q  <= cmd_idx;
              k_q    <= '0;
              acc_q  <= '0;
              fold_q <= !seen_i[cmd_idx];
              st_q   <= ST_REQ;
            end
            OP_COLSUM: begin
              if (all_seen_i) begin
                rsp_q <= sel_data_i;
                st_q  <= ST_RESP;
              end else begin
                row_q  <= 1'b0;
                idx_q  <= cmd_idx;
                k_q    <= '0;
                acc_q  <= '0;
                fold_q <= 1'b0;
                st_q   <= ST_REQ;
              end
            end
            default: begin
              rsp_q <= '0;
              st_q  <= ST_RESP;
            end
          endcase
        end
        ST_REQ: if (mem_req_ready_i) st_q <= ST_WAIT;
        ST_WAIT: if (hit) begin
          acc_q <= sum_nxt;
          tag_q <= tag_q + TAG_W'(1);
          if (last) begin
            rsp_q <= sum_nxt;
            st_q  <= ST_RESP;
          end else begin
            k_q  <= k_q + IDX_W'(1);
            st_q <= ST_REQ;
          end
        end
        ST_RESP: if (rsp_ready_i) st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign cmd_ready_o     = (st_q == ST_IDLE);
  assign rsp_valid_o     = (st_q == ST_RESP);
  assign rsp_data_o      = rsp_q;
  assign mem_req_valid_o = (st_q == ST_REQ);
  assign mem_req_tag_o   = tag_q;

  assign n_o        = n_q;
  assign base_o     = base_q;
  assign walk_row_o = row_q;
  assign walk_idx_o = idx_q;
  assign walk_k_o   = k_q;

  assign clr_o      = fire && (op == OP_SETUP);
  assign add_o      = hit && row_q && fold_q;
  assign add_idx_o  = k_q;
  assign add_data_o = mem_rsp_data_i;
  assign mark_o     = hit && last && row_q && fold_q;
  assign mark_idx_o = idx_q;
  assign sel_idx_o  = cmd_idx;
endmodule

// File: rtl/msum_accel.sv
module msum_accel
  import msum_pkg::*;
#(
  parameter int NMAX  = 16,
  parameter int TAG_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cmd_valid_i,
  output logic             cmd_ready_o,
  input  logic [31:0]      cmd_opcode_i,
  input  logic [63:0]      cmd_rs1_i,
  input  logic [63:0]      cmd_rs2_i,
  output logic             rsp_valid_o,
  input  logic             rsp_ready_i,
  output logic [63:0]      rsp_data_o,
  output logic             mem_req_valid_o,
  input  logic             mem_req_ready_i,
  output logic [TAG_W-1:0] mem_req_tag_o,
  output logic [7:0]       mem_req_mask_o,
  output logic [1:0]       mem_req_type_o,
  output logic [63:0]      mem_req_addr_o,
  output logic [63:0]      mem_req_wdata_o,
  input  logic             mem_rsp_valid_i,
  input  logic [TAG_W-1:0] mem_rsp_tag_i,
  input  logic [7:0]       mem_rsp_mask_i,
  input  logic [63:0]      mem_rsp_data_i
);
  localparam int IDX_W = (NMAX > 1) ? $clog2(NMAX) : 1;
  localparam int CNT_W = $clog2(NMAX + 1);

  logic [CNT_W-1:0] n;
  logic [63:0]      base;
  logic             walk_row;
  logic [IDX_W-1:0] walk_idx, walk_k;
  logic             clr, add, mark;
  logic [IDX_W-1:0] add_idx, mark_idx, sel_idx;
  logic [63:0]      add_data, sel_data;
  logic [NMAX-1:0]  seen;
  logic             all_seen;
  logic             unused_mask;

  assign unused_mask = ^mem_rsp_mask_i;

  msum_ctrl #(.NMAX(NMAX), .TAG_W(TAG_W)) u_ctrl (
    .clk_i, .rst_ni,
    .cmd_valid_i, .cmd_ready_o, .cmd_opcode_i, .cmd_rs1_i, .cmd_rs2_i,
    .rsp_valid_o, .rsp_ready_i, .rsp_data_o,
    .mem_req_valid_o, .mem_req_ready_i, .mem_req_tag_o,
    .mem_rsp_valid_i, .mem_rsp_tag_i, .mem_rsp_data_i,
    .n_o(n), .base_o(base), .walk_row_o(walk_row), .walk_idx_o(walk_idx), .walk_k_o(walk_k),
    .clr_o(clr), .add_o(add), .add_idx_o(add_idx), .add_data_o(add_data),
    .mark_o(mark), .mark_idx_o(mark_idx), .sel_idx_o(sel_idx),
    .sel_data_i(sel_data), .seen_i(seen), .all_seen_i(all_seen)
  );

  msum_colbank #(.NMAX(NMAX)) u_colbank (
    .clk_i, .rst_ni,
    .n_i(n), .clr_i(clr), .add_i(add), .add_idx_i(add_idx), .add_data_i(add_data),
    .mark_i(mark), .mark_idx_i(mark_idx), .sel_idx_i(sel_idx),
    .sel_data_o(sel_data), .seen_o(seen), .all_seen_o(all_seen)
  );

  msum_addr_gen #(.NMAX(NMAX)) u_addr (
    .base_i(base), .n_i(n), .row_i(walk_row), .idx_i(walk_idx), .k_i(walk_k),
    .addr_o(mem_req_addr_o)
  );

  assign mem_req_mask_o  = MEM_FULL_MASK;
  assign mem_req_type_o  = MEM_LOAD;
  assign mem_req_wdata_o = '0;
endmodule

// File: rtl/msum_accel_chk.sv
module msum_accel_chk
  import msum_pkg::*;
#(
  parameter int TAG_W = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cmd_valid_i,
  input logic             cmd_ready_o,
  input logic [31:0]      cmd_opcode_i,
  input logic             rsp_valid_o,
  input logic             rsp_ready_i,
  input logic [63:0]      rsp_data_o,
  input logic             mem_req_valid_o,
  input logic             mem_req_ready_i,
  input logic [TAG_W-1:0] mem_req_tag_o,
  input logic [7:0]       mem_req_mask_o,
  input logic [1:0]       mem_req_type_o,
  input logic [63:0]      mem_req_addr_o,
  input logic [63:0]      mem_req_wdata_o,
  input logic             mem_rsp_valid_i,
  input logic [TAG_W-1:0] mem_rsp_tag_i,
  input logic             all_seen
);
  logic             out_q, fast_q;
  logic [TAG_W-1:0] out_tag_q;
  logic             req_fire, rsp_match;

  assign req_fire  = mem_req_valid_o && mem_req_ready_i;
  assign rsp_match = mem_rsp_valid_i && (mem_rsp_tag_i == out_tag_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_q     <= 1'b0;
      out_tag_q <= '0;
      fast_q    <= 1'b0;
    end else begin
      if (req_fire) begin
        out_q     <= 1'b1;
        out_tag_q <= mem_req_tag_o;
      end else if (out_q && rsp_match) begin
        out_q <= 1'b0;
      end
      if (cmd_valid_i && cmd_ready_o && op_e'(cmd_opcode_i[1:0]) == OP_COLSUM && all_seen)
        fast_q <= 1'b1;
      else if (rsp_valid_o && rsp_ready_i)
        fast_q <= 1'b0;
    end
  end

  p_idle_excl_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_ready_o |-> !rsp_valid_o && !mem_req_valid_o);

  p_rsp_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && !rsp_ready_i |=> rsp_valid_o && $stable(rsp_data_o));

  p_req_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_valid_o && !mem_req_ready_i |=>
      mem_req_valid_o && $stable(mem_req_addr_o) && $stable(mem_req_tag_o));

  p_req_fields_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_valid_o |-> mem_req_type_o == MEM_LOAD && mem_req_mask_o == MEM_FULL_MASK &&
                        mem_req_addr_o[2:0] == 3'b000 && mem_req_wdata_o == 64'd0);

  p_one_out_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_q |-> !mem_req_valid_o);

  p_stray_ignored_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_q && mem_rsp_valid_i && mem_rsp_tag_i != out_tag_q |=> !mem_req_valid_o && !rsp_valid_o);

  p_cached_quiet_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fast_q |-> !mem_req_valid_o);
endmodule

bind msum_accel msum_accel_chk #(.TAG_W(TAG_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni),
  .cmd_valid_i(cmd_valid_i), .cmd_ready_o(cmd_ready_o), .cmd_opcode_i(cmd_opcode_i),
  .rsp_valid_o(rsp_valid_o), .rsp_ready_i(rsp_ready_i), .rsp_data_o(rsp_data_o),
  .mem_req_valid_o(mem_req_valid_o), .mem_req_ready_i(mem_req_ready_i),
  .mem_req_tag_o(mem_req_tag_o), .mem_req_mask_o(mem_req_mask_o),
  .mem_req_type_o(mem_req_type_o), .mem_req_addr_o(mem_req_addr_o),
  .mem_req_wdata_o(mem_req_wdata_o),
  .mem_rsp_valid_i(mem_rsp_valid_i), .mem_rsp_tag_i(mem_rsp_tag_i),
  .all_seen(all_seen)
);

// File: tb/msum_accel_bench.sv
`timescale 1ns/1ps
module msum_accel_bench;
  localparam int TAG_W = 4;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic             cmd_valid_i = 1'b0;
  logic             cmd_ready_o;
  logic [31:0]      cmd_opcode_i = '0;
  logic [63:0]      cmd_rs1_i = '0;
  logic [63:0]      cmd_rs2_i = '0;
  logic             rsp_valid_o;
  logic             rsp_ready_i = 1'b1;
  logic [63:0]      rsp_data_o;
  logic             mem_req_valid_o;
  logic             mem_req_ready_i = 1'b0;
  logic [TAG_W-1:0] mem_req_tag_o;
  logic [7:0]       mem_req_mask_o;
  logic [1:0]       mem_req_type_o;
  logic [63:0]      mem_req_addr_o;
  logic [63:0]      mem_req_wdata_o;
  logic             mem_rsp_valid_i = 1'b0;
  logic [TAG_W-1:0] mem_rsp_tag_i = '0;
  logic [7:0]       mem_rsp_mask_i = 8'hFF;
  logic [63:0]      mem_rsp_data_i = '0;

  always #2.5 clk_i = ~clk_i;

  msum_accel u_msum_accel (.*);

  int n_chk = 0;
  int n_fail = 0;
  int req_cnt = 0;
  int cyc = 0;
  int cur_p = 0;
  int cur_n = 1;
  logic [63:0] cur_base = 64'h1000;

  bit               pend = 1'b0;
  int               pend_cnt = 0;
  logic [TAG_W-1:0] pend_tag = '0;
  logic [63:0]      pend_data = '0;

  function automatic logic [63:0] elem(int p, int n, int r, int c);
    if (p == 0) return 64'(r * n + c + 1);
    return 64'h9E37_79B9_7F4A_7C15 * 64'(r + 1) + 64'(c) * 64'hFFFF_FFFF_0000_0123;
  endfunction

  function automatic logic [63:0] row_sum(int p, int n, int r);
    logic [63:0] s = '0;
    for (int c = 0; c < n; c++) s += elem(p, n, r, c);
    return s;
  endfunction

  function automatic logic [63:0] col_sum(int p, int n, int c);
    logic [63:0] s = '0;
    for (int r = 0; r < n; r++) s += elem(p, n, r, c);
    return s;
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // memory model: one load at a time, stray wrong-tag reply before each real one
  always @(negedge clk_i) begin
    logic [63:0] off;
    mem_rsp_valid_i = 1'b0;
    mem_rsp_tag_i   = '0;
    mem_rsp_data_i  = '0;
    if (pend) begin
      if (pend_cnt == 0) begin
        mem_rsp_valid_i = 1'b1;
        mem_rsp_tag_i   = pend_tag;
        mem_rsp_data_i  = pend_data;
        pend = 1'b0;
      end else begin
        if (pend_cnt == 1) begin
          mem_rsp_valid_i = 1'b1;
          mem_rsp_tag_i   = pend_tag ^ TAG_W'(1);
          mem_rsp_data_i  = 64'hBAD0_BAD0_BAD0_BAD0;
        end
        pend_cnt--;
      end
    end
    if (rst_ni && mem_req_valid_o && mem_req_ready_i) begin
      off = mem_req_addr_o - cur_base;
      n_chk++;
      if (off[2:0] != 3'b000 || (off >> 3) >= 64'(cur_n * cur_n) ||
          mem_req_type_o != 2'd0 || mem_req_mask_o != 8'hFF) begin
        n_fail++;
        $display("FAIL R7: actual addr %0h type %0d mask %0h expected in-matrix load mask ff",
                 mem_req_addr_o, mem_req_type_o, mem_req_mask_o);
      end
      pend      = 1'b1;
      pend_cnt  = 1 + (req_cnt % 3);
      pend_tag  = mem_req_tag_o;
      pend_data = elem(cur_p, cur_n, int'((off >> 3) / 64'(cur_n)), int'((off >> 3) % 64'(cur_n)));
      req_cnt++;
    end
    mem_req_ready_i = (cyc % 3) != 2;
    cyc++;
  end

  task automatic run_cmd(input logic [1:0] op, input logic [63:0] a, input logic [63:0] b,
                         output logic [63:0] res, output int reqs);
    int start;
    @(negedge clk_i);
    start = req_cnt;
    cmd_opcode_i = 32'hABCD_0000 | 32'(op);
    cmd_rs1_i = a;
    cmd_rs2_i = b;
    cmd_valid_i = 1'b1;
    while (!cmd_ready_o) @(negedge clk_i);
    @(negedge clk_i);
    cmd_valid_i = 1'b0;
    while (!rsp_valid_o) @(negedge clk_i);
    res = rsp_data_o;
    reqs = req_cnt - start;
    @(negedge clk_i);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk_i);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin : main
    logic [63:0] res;
    int reqs;
    int nlist[6] = '{1, 2, 3, 4, 7, 16};
    bit first = 1'b1;

    repeat (3) @(negedge clk_i);
    chk("R10 cmd_ready", 64'(cmd_ready_o), 64'd1);
    chk("R10 rsp_valid", 64'(rsp_valid_o), 64'd0);
    chk("R10 mem_req_valid", 64'(mem_req_valid_o), 64'd0);
    rst_ni = 1'b1;

    for (int p = 0; p < 2; p++) begin
      for (int ni = 0; ni < 6; ni++) begin
        int n = nlist[ni];
        cur_p = p;
        cur_n = n;
        cur_base = 64'h1000 + 64'(p) * 64'h8000 + 64'(n) * 64'h100;

        if (first) begin
          // R6: held response, no new command accepted while it waits
          first = 1'b0;
          rsp_ready_i = 1'b0;
          @(negedge clk_i);
          cmd_opcode_i = 32'(0);
          cmd_rs1_i = 64'(n);
          cmd_rs2_i = cur_base;
          cmd_valid_i = 1'b1;
          @(negedge clk_i);
          cmd_valid_i = 1'b0;
          for (int w = 0; w < 3; w++) begin
            chk("R6 rsp held", 64'(rsp_valid_o), 64'd1);
            chk("R6 cmd blocked", 64'(cmd_ready_o), 64'd0);
            chk("R1 R6 setup data", rsp_data_o, 64'd0);
            @(negedge clk_i);
          end
          rsp_ready_i = 1'b1;
          @(negedge clk_i);
          chk("R6 ready after take", 64'(cmd_ready_o), 64'd1);
          chk("R6 rsp dropped", 64'(rsp_valid_o), 64'd0);
        end else begin
          run_cmd(2'd0, 64'(n), cur_base, res, reqs);
          chk("R1 setup data", res, 64'd0);
          chk("R1 setup loads", 64'(reqs), 64'd0);
        end

        for (int c = 0; c < n; c++) begin
          run_cmd(2'd2, 64'(c), 64'd0, res, reqs);
          chk("R3 R8 col sum fetched", res, col_sum(p, n, c));
          chk("R3 col loads", 64'(reqs), 64'(n));
        end

        for (int r = 0; r < n; r++) begin
          run_cmd(2'd1, 64'(r), 64'd0, res, reqs);
          chk("R2 R8 row sum", res, row_sum(p, n, r));
          chk("R2 row loads", 64'(reqs), 64'(n));
          if (r == n - 2) begin
            run_cmd(2'd2, 64'(n - 1), 64'd0, res, reqs);
            chk("R3 R5 col before last row", res, col_sum(p, n, n - 1));
            chk("R5 col before last row loads", 64'(reqs), 64'(n));
          end
        end

        run_cmd(2'd1, 64'd0, 64'd0, res, reqs);
        chk("R4 repeated row sum", res, row_sum(p, n, 0));
        chk("R4 repeated row loads", 64'(reqs), 64'(n));

        for (int c = 0; c < n; c++) begin
          run_cmd(2'd2, 64'(c), 64'd0, res, reqs);
          chk("R4 R5 cached col sum", res, col_sum(p, n, c));
          chk("R5 cached col loads", 64'(reqs), 64'd0);
        end

        run_cmd(2'd3, 64'(n - 1), 64'hFFFF_FFFF_FFFF_FFF8, res, reqs);
        chk("R9 undefined op data", res, 64'd0);
        chk("R9 undefined op loads", 64'(reqs), 64'd0);
        run_cmd(2'd2, 64'(n - 1), 64'd0, res, reqs);
        chk("R9 state kept", res, col_sum(p, n, n - 1));
        chk("R9 state kept loads", 64'(reqs), 64'd0);

        run_cmd(2'd0, 64'(n), cur_base, res, reqs);
        run_cmd(2'd2, 64'd0, 64'd0, res, reqs);
        chk("R1 cleared col", res, col_sum(p, n, 0));
        chk("R1 cleared col loads", 64'(reqs), 64'(n));
      end
    end

    summary();
    $finish;
  end
endmodule